// File: doc/BRIEF.md
# Three-Wire Codec Control Port

This block receives 16-bit control words over a three-line serial port (shift clock, data, strobe). It decodes each word into one of four option registers for a stereo audio codec. The three serial lines may be driven by a host that has no timing relation to the codec's system clock, so each line passes through a synchronizer before any edge is detected. All decoding, storage and pulses are in the system-clock domain.

A word is shifted in most significant bit first, one bit on each rising shift-clock edge while the strobe is low. The word is acted on when the strobe rises. Two address bits in the word pick the target register:

- Attenuation for the left channel.
- Attenuation for the right channel.
- DAC/ADC options: power-down, high-pass bypass, common attenuation, zero detect, output disable, de-emphasis and mute.
- Interface options: loopback, audio data format and word-clock polarity.

Every decoded field is a plain output. A one-cycle commit pulse marks which register was written. A separate one-cycle apply pulse tells the downstream attenuator to adopt both pending attenuation codes.

Top module: `codec_ctrl_port`

## Requirements
- R1: After reset the outputs are as follows:
  - both attenuation codes are FFh;
  - the format is 000 and the word-clock polarity is 0;
  - power-down, high-pass bypass, common attenuation, zero detect, output disable, mute and loopback are 0;
  - de-emphasis is 00;
  - commit and apply are low.
- R2: A word is 16 bits. Bits are sampled on rising shift-clock edges while the strobe is low, and the first bit sampled is bit 15. The word takes effect on the strobe rising edge.
- R3: Word bits 10:9 select the register (0 left attenuation, 1 right attenuation, 2 options, 3 interface). Each write raises only `commit_o[addr]`, for exactly one cycle. The fields of the other registers do not change.
- R4: In registers 0 and 1, bits 7:0 are the attenuation code and bit 8 is the load bit.
- R5: In register 2:
  - bit 8 is power-down;
  - bit 7 is high-pass bypass;
  - bit 5 is common attenuation;
  - bit 4 is zero detect;
  - bit 3 is output disable;
  - bits 2:1 are de-emphasis (00 off, 01 48 kHz, 10 44.1 kHz, 11 32 kHz);
  - bit 0 is mute.
- R6: In register 3, bit 5 is loopback, bits 4:2 are the format and bit 1 is the word-clock polarity. Reserved bits have no effect on any output: bits 15:11 of every word, bit 6 of register 2, and bits 8:6 and 0 of register 3.
- R7: Writing register 0 or 1 with bit 8 set raises `att_apply_o` for one cycle, in the same cycle as the commit. A write with bit 8 clear, or any write to register 2 or 3, gives no apply pulse.
- R8: A strobe rising edge after any number of sampled bits other than 16 discards the word. There is no commit, no apply and no field change. Counting restarts when the strobe falls.
- R9: `loopback_o` is 0 whenever the format is 110, whatever the stored loopback bit is. The stored bit takes effect again once the format changes.
- R10: The commit pulse and the new field values appear SYNC_STAGES+2 system-clock edges after the strobe input rises (4 with the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_sck_i | input | 1 | Serial shift clock (asynchronous) |
| ctl_sdi_i | input | 1 | Serial data (asynchronous) |
| ctl_stb_i | input | 1 | Strobe, low while a word is shifted (asynchronous) |
| att_left_o | output | 8 | Left attenuation code |
| att_right_o | output | 8 | Right attenuation code |
| att_apply_o | output | 1 | One-cycle pulse: attenuator adopts both codes |
| commit_o | output | 4 | One-hot, one-cycle pulse per register written |
| adc_pdn_o | output | 1 | ADC power-down |
| hpf_bypass_o | output | 1 | High-pass filter bypass |
| att_common_o | output | 1 | Left code used for both channels |
| zero_det_o | output | 1 | Zero detection enable |
| out_disable_o | output | 1 | DAC output disable |
| deemph_o | output | 2 | De-emphasis select |
| mute_o | output | 1 | Soft mute |
| loopback_o | output | 1 | Effective loopback enable |
| fmt_o | output | 3 | Audio data format |
| lr_pol_o | output | 1 | Word-clock polarity |

## Verification
With two synchronizer stages, the commit pulse, the apply pulse and the new field values are all due 4 system-clock edges after the bench raises the strobe. The whole chain is:

- two synchronizer flops;
- the edge-detect and word-valid register;
- the register-file update.

The bench counts clock edges from the moment it drives the strobe high. Its monitor compares each commit against a queued expectation at the falling edge that follows, and it requires the count to be exactly 4. Discarded words are checked by the absence of any unexpected commit and by a field snapshot taken after the commit window has passed.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 2;
    localparam int N_REGS   = 1 << ADDR_W;
    localparam int ADDR_LSB = 9;
    localparam int ATT_W    = 8;
    localparam int LOAD_BIT = 8;
    localparam int FMT_W    = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ATT_L = 2'd0,
        SEL_ATT_R = 2'd1,
        SEL_OPTS  = 2'd2,
        SEL_IFACE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        DE_OFF  = 2'b00,
        DE_48K  = 2'b01,
        DE_44K1 = 2'b10,
        DE_32K  = 2'b11
    } deemph_e;

    typedef enum logic [FMT_W-1:0] {
        FMT_R16_L16 = 3'b000,
        FMT_R18_L18 = 3'b001,
        FMT_R16_R16 = 3'b010,
        FMT_R18_R18 = 3'b011,
        FMT_LJ      = 3'b100,
        FMT_I2S     = 3'b101,
        FMT_FRAME   = 3'b110,
        FMT_RSVD    = 3'b111
    } fmt_e;

    typedef struct packed {
        logic    pdn;
        logic    hpf_byp;
        logic    att_common;
        logic    zero_det;
        logic    out_dis;
        deemph_e deemph;
        logic    mute;
    } opts_t;

    typedef struct packed {
        logic loop_en;
        fmt_e fmt;
        logic lr_pol;
    } iface_t;

    localparam logic [ATT_W-1:0] ATT_DEFAULT = '1;

    localparam opts_t OPTS_DEFAULT = '{
        pdn: 1'b0, hpf_byp: 1'b0, att_common: 1'b0, zero_det: 1'b0,
        out_dis: 1'b0, deemph: DE_OFF, mute: 1'b0
    };

    localparam iface_t IFACE_DEFAULT = '{
        loop_en: 1'b0, fmt: FMT_R16_L16, lr_pol: 1'b0
    };

    function automatic opts_t decode_opts(input logic [LOAD_BIT:0] f);
        opts_t o;
        o.pdn        = f[8];
        o.hpf_byp    = f[7];
        o.att_common = f[5];
        o.zero_det   = f[4];
        o.out_dis    = f[3];
        o.deemph     = deemph_e'(f[2:1]);
        o.mute       = f[0];
        return o;
    endfunction

    function automatic iface_t decode_iface(input logic [5:1] f);
        iface_t r;
        r.loop_en = f[5];
        r.fmt     = fmt_e'(f[4:2]);
        r.lr_pol  = f[1];
        return r;
    endfunction

    function automatic logic loop_allowed(input fmt_e f);
        return f != FMT_FRAME;
    endfunction

endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
    parameter int               N_LINES = 3,
    parameter int               STAGES  = 2,
    parameter logic [N_LINES-1:0] RST_VAL = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] din,
    output logic [N_LINES-1:0] dout
);

    logic [N_LINES-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/ccp_shifter.sv
module ccp_shifter
    import ccp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              stb_s,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);

    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int CNT_TOP = WORD_W + 1;

    logic              sck_q;
    logic              stb_q;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              sck_rise;
    logic              stb_rise;
    logic              stb_fall;

    assign sck_rise =  sck_s && !sck_q;
    assign stb_rise =  stb_s && !stb_q;
    assign stb_fall = !stb_s &&  stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            stb_q    <= 1'b1;
            shreg    <= '0;
            cnt      <= '0;
            word_vld <= 1'b0;
        end else begin
            sck_q    <= sck_s;
            stb_q    <= stb_s;
            word_vld <= 1'b0;
            if (stb_fall) begin
                cnt <= '0;
            end else if (stb_rise) begin
                word_vld <= (cnt == CNT_W'(WORD_W));
                cnt      <= '0;
            end else if (!stb_s && sck_rise) begin
                shreg <= {shreg[WORD_W-2:0], sdi_s};
                if (cnt != CNT_W'(CNT_TOP)) cnt <= cnt + 1'b1;
            end
        end
    end

    assign word = shreg;

endmodule

// File: rtl/ccp_regfile.sv
module ccp_regfile
    import ccp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output logic [ATT_W-1:0]  att_left,
    output logic [ATT_W-1:0]  att_right,
    output opts_t             opts,
    output iface_t            iface,
    output logic [N_REGS-1:0] commit,
    output logic              apply
);

    reg_sel_e         sel;
    logic [ATT_W-1:0] code;
    logic             load;
    logic             unused_rsvd;

    assign sel         = reg_sel_e'(word[ADDR_LSB +: ADDR_W]);
    assign code        = word[ATT_W-1:0];
    assign load        = word[LOAD_BIT];
    assign unused_rsvd = ^word[WORD_W-1:ADDR_LSB+ADDR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            att_left  <= ATT_DEFAULT;
            att_right <= ATT_DEFAULT;
            opts      <= OPTS_DEFAULT;
            iface     <= IFACE_DEFAULT;
            commit    <= '0;
            apply     <= 1'b0;
        end else begin
            commit <= '0;
            apply  <= 1'b0;
            if (word_vld) begin
                commit[sel] <= 1'b1;
                unique case (sel)
                    SEL_ATT_L: begin
                        att_left <= code;
                        apply    <= load;
                    end
                    SEL_ATT_R: begin
                        att_right <= code;
                        apply     <= load;
                    end
                    SEL_OPTS:  opts  <= decode_opts(word[LOAD_BIT:0]);
                    SEL_IFACE: iface <= decode_iface(word[5:1]);
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/codec_ctrl_port.sv
module codec_ctrl_port
    import ccp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_sck_i,
    input  logic       ctl_sdi_i,
    input  logic       ctl_stb_i,
    output logic [7:0] att_left_o,
    output logic [7:0] att_right_o,
    output logic       att_apply_o,
    output logic [3:0] commit_o,
    output logic       adc_pdn_o,
    output logic       hpf_bypass_o,
    output logic       att_common_o,
    output logic       zero_det_o,
    output logic       out_disable_o,
    output logic [1:0] deemph_o,
    output logic       mute_o,
    output logic       loopback_o,
    output logic [2:0] fmt_o,
    output logic       lr_pol_o
);

    localparam int N_LINES = 3;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               word_vld;
    logic [WORD_W-1:0]  word;
    opts_t              opts;
    iface_t             iface;

    assign raw_lines = {ctl_stb_i, ctl_sdi_i, ctl_sck_i};

    ccp_sync #(
        .N_LINES (N_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    ccp_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (sync_lines[0]),
        .sdi_s    (sync_lines[1]),
        .stb_s    (sync_lines[2]),
        .word_vld (word_vld),
        .word     (word)
    );

    ccp_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .word_vld  (word_vld),
        .word      (word),
        .att_left  (att_left_o),
        .att_right (att_right_o),
        .opts      (opts),
        .iface     (iface),
        .commit    (commit_o),
        .apply     (att_apply_o)
    );

    assign adc_pdn_o     = opts.pdn;
    assign hpf_bypass_o  = opts.hpf_byp;
    assign att_common_o  = opts.att_common;
    assign zero_det_o    = opts.zero_det;
    assign out_disable_o = opts.out_dis;
    assign deemph_o      = opts.deemph;
    assign mute_o        = opts.mute;
    assign fmt_o         = iface.fmt;
    assign lr_pol_o      = iface.lr_pol;
    assign loopback_o    = iface.loop_en && loop_allowed(iface.fmt);

endmodule

// File: rtl/ccp_checker.sv
module ccp_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] commit_o,
    input logic       att_apply_o,
    input logic [7:0] att_left_o,
    input logic [7:0] att_right_o,
    input logic       adc_pdn_o,
    input logic [1:0] deemph_o,
    input logic       mute_o,
    input logic       loopback_o,
    input logic [2:0] fmt_o
);

    p_reset_defaults_r1: assert property (@(posedge clk)
        $past(rst) |-> (att_left_o == 8'hFF && att_right_o == 8'hFF &&
                        fmt_o == 3'b000 && !loopback_o && commit_o == 4'b0));

    p_commit_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(commit_o));

    p_commit_single_r3: assert property (@(posedge clk) disable iff (rst)
        (commit_o != 4'b0) |=> (commit_o == 4'b0));

    p_left_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !commit_o[0] |-> $stable(att_left_o));

    p_right_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !commit_o[1] |-> $stable(att_right_o));

    p_opts_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !commit_o[2] |-> ($stable(adc_pdn_o) && $stable(deemph_o) && $stable(mute_o)));

    p_apply_with_att_r7: assert property (@(posedge clk) disable iff (rst)
        att_apply_o |-> (commit_o[0] || commit_o[1]));

    p_no_loop_frame_r9: assert property (@(posedge clk) disable iff (rst)
        (fmt_o == 3'b110) |-> !loopback_o);

endmodule

bind codec_ctrl_port ccp_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .commit_o    (commit_o),
    .att_apply_o (att_apply_o),
    .att_left_o  (att_left_o),
    .att_right_o (att_right_o),
    .adc_pdn_o   (adc_pdn_o),
    .deemph_o    (deemph_o),
    .mute_o      (mute_o),
    .loopback_o  (loopback_o),
    .fmt_o       (fmt_o)
);

// File: tb/sim_codec_ctrl_port.sv
module sim_codec_ctrl_port;

    localparam int HALF    = 3;
    localparam int LATENCY = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       stb = 1'b1;
    logic [7:0] att_l, att_r;
    logic       apply, pdn, byp, atc, zd, od, mute, lop, lrp;
    logic [3:0] commit;
    logic [1:0] dem;
    logic [2:0] fmt;

    int n_chk  = 0;
    int n_fail = 0;
    int since_stb = 0;

    always #2 clk = ~clk;

    codec_ctrl_port u0 (
        .clk(clk), .rst(rst),
        .ctl_sck_i(sck), .ctl_sdi_i(sdi), .ctl_stb_i(stb),
        .att_left_o(att_l), .att_right_o(att_r), .att_apply_o(apply),
        .commit_o(commit), .adc_pdn_o(pdn), .hpf_bypass_o(byp),
        .att_common_o(atc), .zero_det_o(zd), .out_disable_o(od),
        .deemph_o(dem), .mute_o(mute), .loopback_o(lop),
        .fmt_o(fmt), .lr_pol_o(lrp)
    );

    typedef struct {
        logic [3:0]  com;
        logic        app;
        logic [28:0] fld;
        string       req;
    } exp_t;
    exp_t q[$];

    logic [7:0] m_l = 8'hFF, m_r = 8'hFF;
    logic m_pdn = 0, m_byp = 0, m_atc = 0, m_zd = 0, m_od = 0, m_mute = 0;
    logic m_lop = 0, m_lrp = 0;
    logic [1:0] m_dem = 2'b00;
    logic [2:0] m_fmt = 3'b000;

    function automatic logic [28:0] dut_fields();
        return {att_l, att_r, pdn, byp, atc, zd, od, dem, mute, lop, fmt, lrp};
    endfunction

    function automatic logic [28:0] model_fields();
        return {m_l, m_r, m_pdn, m_byp, m_atc, m_zd, m_od, m_dem, m_mute,
                m_lop && (m_fmt != 3'b110), m_fmt, m_lrp};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) since_stb <= since_stb + 1;

    // monitor: pops one expectation per commit
    always @(negedge clk) begin
        if (!rst && (commit != 4'b0 || apply)) begin
            if (q.size() == 0) begin
                chk(0, "R8", "unexpected commit", {27'b0, apply, commit}, 32'b0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(commit == e.com, "R3", "commit", {28'b0, commit}, {28'b0, e.com});
                chk(apply == e.app, "R7", "apply", {31'b0, apply}, {31'b0, e.app});
                chk(dut_fields() == e.fld, e.req, "fields", {3'b0, dut_fields()}, {3'b0, e.fld});
                chk(since_stb == LATENCY, "R10", "latency", since_stb, LATENCY);
            end
        end
    end

    task automatic shift_bits(input logic [31:0] bits, input int n);
        @(negedge clk) stb = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic raise_strobe();
        stb = 1'b1;
        since_stb = 0;
        repeat (LATENCY + 4) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] w, input string req);
        exp_t e;
        e.com = 4'b0;
        e.app = 1'b0;
        case (w[10:9])
            2'd0: begin m_l = w[7:0]; e.app = w[8]; end
            2'd1: begin m_r = w[7:0]; e.app = w[8]; end
            2'd2: begin
                m_pdn = w[8]; m_byp = w[7]; m_atc = w[5]; m_zd = w[4];
                m_od = w[3]; m_dem = w[2:1]; m_mute = w[0];
            end
            default: begin m_lop = w[5]; m_fmt = w[4:2]; m_lrp = w[1]; end
        endcase
        e.com[w[10:9]] = 1'b1;
        e.fld = model_fields();
        e.req = req;
        shift_bits({16'b0, w}, 16);
        q.push_back(e);
        raise_strobe();
    endtask

    task automatic bad_word(input logic [31:0] bits, input int n);
        shift_bits(bits, n);
        raise_strobe();
        chk(dut_fields() == model_fields(), "R8", $sformatf("discard %0d bits", n),
            {3'b0, dut_fields()}, {3'b0, model_fields()});
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R2", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 defaults
        chk(dut_fields() == model_fields(), "R1", "reset fields",
            {3'b0, dut_fields()}, {3'b0, model_fields()});
        chk(commit == 4'b0 && !apply, "R1", "reset pulses", {27'b0, apply, commit}, 0);

        write_word(16'h0081, "R2");          // MSB-first pattern, left code 81h
        write_word(16'h0012, "R4");          // left code, no load
        write_word(16'h035A, "R4");          // right code 5Ah with load
        write_word(16'h0505, "R5");          // pdn, de-emph 44.1k, mute
        write_word(16'h04FA, "R6");          // byp/atc/zd/od, de-emph 48k, reserved bit 6
        write_word(16'hFFF7, "R6");          // iface: loop, fmt 101, pol 1, all reserved set
        write_word(16'h0638, "R9");          // fmt 110 with loop -> loopback off
        chk(lop == 1'b0, "R9", "loopback in frame format", {31'b0, lop}, 0);
        write_word(16'h0630, "R9");          // fmt 100 with loop -> loopback on
        chk(lop == 1'b1, "R9", "loopback restored", {31'b0, lop}, 1);
        write_word(16'h0100, "R7");          // left load with code 00
        write_word(16'h02C3, "R7");          // right no load
        write_word(16'h0400, "R5");          // opts cleared

        bad_word(32'h0000_7FFF, 15);
        bad_word(32'h0001_03AA, 17);
        bad_word(32'h0, 0);

        write_word(16'h0403, "R5");          // de-emph 01, mute after discards
        chk(q.size() == 0, "R2", "pending commits", q.size(), 0);
        finish_run();
    end

endmodule